// File: doc/BRIEF.md
# Five-Channel Timer with Infrared Carrier Modulation

This block is a 16-bit up-counting timer with five channels that can each either generate a pulse-width waveform or timestamp edges on an input pin. The counter runs from zero to a programmed period and wraps. A selectable prescaler sits in front of it. Period and compare writes are double-buffered, so a change never lands mid-cycle while the timer runs.

An 8-bit carrier timer is built in. It has its own prescaler, period and compare value, and produces a square carrier. In infrared mode the main counter stops counting prescaled clocks and advances once per carrier period. Channel 0's waveform is then ANDed with the carrier to give a modulated infrared output.

Software reaches the block through a single-cycle write port and a combinational read port. The interrupt output rises on counter wrap or on any capture.

Top module: `irt_timer`

## Requirements
- R1: After a synchronous active-low reset, all channel outputs, `irq`, `carrier_out` and `ir_out` are 0. The counter (read address 4) and the flag register (address 3) read 0.
- R2: Bits [2:1] of the control register (address 0) select the main prescale ratio: 00 gives /1, 01 gives /8, 10 gives /32 and 11 gives /128. Bit 0 is the run enable.
- R3: While running, the counter counts 0..PERIOD (address 1) and then wraps to 0. Each wrap sets flag bit 0 and drives `irq` high. Writing a 1 to that flag bit clears it.
- R4: A channel in compare mode drives its output high while the counter is below its compare value (address 16+i). Over one full period its output is high for min(C, PERIOD+1) counter steps.
- R5: A compare value of 0 holds the channel output low.
- R6: While running, period and compare writes take effect only at the next wrap. While stopped, they take effect at once. A compare-address read returns the active value.
- R7: Control bit 3 selects infrared mode. In this mode the counter advances once per carrier period, and `ir_out` equals channel 0's output ANDed with `carrier_out`. In any other mode `ir_out` is 0.
- R8: Channel configuration register 8+i: bit 0 = 1 selects capture mode, bit 1 enables rising-edge capture and bit 2 enables falling-edge capture. A selected edge on `cap_in[i]` records the counter value, which is readable at address 16+i. It also sets flag bit 1+i. A flag bit is cleared by writing a 1 to it. Unselected edges are ignored.
- R9: Carrier register (address 2): bits [7:0] hold the period and bits [15:8] the compare value. Control bits [5:4] select the carrier prescale with the same coding as R2. `carrier_out` is high while the carrier count is below its compare value.
- R10: A channel in capture mode holds its output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| cap_in | input | 5 | Capture inputs, one per channel |
| ch_out | output | 5 | Channel waveform outputs |
| irq | output | 1 | Wrap or capture interrupt |
| carrier_out | output | 1 | Carrier timer waveform |
| ir_out | output | 1 | Modulated infrared output |

## Verification
The waveform function is measured as high-time counts over whole periods. This is done for directed and randomly drawn period/compare pairs at prescale /1 and /8, with single directed runs at /32 and /128. Compare values below, equal to and above the period separate correct threshold comparison from off-by-one and saturation errors.

Infrared mode uses a carrier whose period differs from the main period. This exposes whether the counter really steps per carrier period and whether gating uses channel 0.

Capture is driven with rising, falling, both and no selected edge, each against a frozen counter value that differs from the previous one. This distinguishes missed captures, wrong edges and stale values.

// File: rtl/irt_pkg.sv
// Package: shared constants, register addresses and the prescale decode for
// the five-channel infrared-capable timer. Assumes a 5-bit register address.
package irt_pkg;
    localparam int ADDR_W  = 5;
    localparam int A_CTRL  = 0;
    localparam int A_PER   = 1;
    localparam int A_CAR   = 2;
    localparam int A_FLAGS = 3;
    localparam int A_COUNT = 4;
    localparam int A_CFG   = 8;
    localparam int A_CMP   = 16;

    // Per-channel configuration: capture enable and edge selection
    typedef struct packed {
        logic fall_en;
        logic rise_en;
        logic cap_mode;
    } ch_cfg_t;

    // Map the 2-bit prescale selector to a power-of-two shift (1,8,32,128)
    function automatic int unsigned div_shift(input logic [1:0] sel);
        case (sel)
            2'b00:   return 0;
            2'b01:   return 3;
            2'b10:   return 5;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/irt_prescaler.sv
// Module: clock-enable prescaler. Emits one tick every 1, 8, 32 or 128
// enabled cycles. Assumes CNT_W is wide enough for the largest ratio.
module irt_prescaler #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       tick
);
    import irt_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected ratio
    always_comb limit = CNT_W'((32'd1 << div_shift(sel)) - 32'd1);

    assign tick = en && (cnt_q >= limit);

    // Divider count: clears when stopped or at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt_q <= '0;
        else if (cnt_q >= limit)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: any ratio above 1 never gives back-to-back ticks
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != 2'b00) |=> (!tick || sel == 2'b00));
endmodule

// File: rtl/irt_carrier.sv
// Module: 8-bit carrier timer with its own prescaler, shadowed period and
// compare. Output is high while its count is below compare. It pulses
// car_wrap when the count wraps. Assumes the period and compare are written
// together as one word.
module irt_carrier #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [1:0]   sel,
    input  logic         wr,
    input  logic [2*W-1:0] wdata,
    output logic         car_out,
    output logic         car_wrap,
    output logic [2*W-1:0] rd_val
);
    logic [W-1:0] ccnt_q, per_sh_q, cmp_sh_q, per_q, cmp_q;
    logic         ctick;

    irt_prescaler #(.CNT_W(7)) i_pre (
        .clk(clk), .rst_n(rst_n), .en(run), .sel(sel), .tick(ctick)
    );

    assign car_wrap = run && ctick && (ccnt_q >= per_q);
    assign car_out  = ccnt_q < cmp_q;
    assign rd_val   = {cmp_q, per_q};

    // Shadow registers capture software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh_q <= '0;
            cmp_sh_q <= '0;
        end else if (wr) begin
            per_sh_q <= wdata[W-1:0];
            cmp_sh_q <= wdata[2*W-1:W];
        end
    end

    // Active values reload at wrap, or continuously while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            cmp_q <= '0;
        end else if (car_wrap || !run) begin
            per_q <= per_sh_q;
            cmp_q <= cmp_sh_q;
        end
    end

    // Carrier count advances on prescaler ticks
    always_ff @(posedge clk) begin
        if (!rst_n)
            ccnt_q <= '0;
        else if (car_wrap)
            ccnt_q <= '0;
        else if (run && ctick)
            ccnt_q <= ccnt_q + 1'b1;
    end

    // R9: the carrier restarts from zero after every wrap
    assert_car_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        car_wrap |=> (ccnt_q == '0));
endmodule

// File: rtl/irt_channel.sv
// Module: one compare/capture channel. In compare mode it produces a waveform
// high while the main count is below a shadowed compare value. In capture
// mode it synchronises its input, detects the selected edges and latches the
// count. Assumes cap_in is asynchronous to clk.
module irt_channel #(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            wrap,
    input  logic [W-1:0]    cnt,
    input  irt_pkg::ch_cfg_t cfg,
    input  logic            cmp_wr,
    input  logic [W-1:0]    wdata,
    input  logic            flag_clr,
    input  logic            cap_in,
    output logic            ch_out,
    output logic            flag,
    output logic [W-1:0]    rd_val
);
    logic [W-1:0] cmp_sh_q, cmp_q, cap_q;
    logic         s1_q, s2_q, s3_q;
    logic         rise, fall, cap_evt;

    assign rise    = s2_q && !s3_q;
    assign fall    = !s2_q && s3_q;
    assign cap_evt = cfg.cap_mode && ((cfg.rise_en && rise) || (cfg.fall_en && fall));
    assign ch_out  = !cfg.cap_mode && (cnt < cmp_q);
    assign rd_val  = cfg.cap_mode ? cap_q : cmp_q;

    // Two-flop synchroniser plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= cap_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Compare shadow takes software writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_sh_q <= '0;
        else if (cmp_wr)
            cmp_sh_q <= wdata;
    end

    // Active compare reloads at wrap or while the timer is stopped
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (wrap || !run)
            cmp_q <= cmp_sh_q;
    end

    // Capture register and its sticky flag (set beats clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            flag  <= 1'b0;
        end else begin
            if (cap_evt)
                cap_q <= cnt;
            if (cap_evt)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
        end
    end

    // R5: a zero compare never lets the waveform rise
    assert_zero_cmp_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q == '0) |-> !ch_out);
    // R6: while running and not wrapping, the active compare holds
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> (run && !$past(wrap)) |-> $stable(cmp_q));
    // R8: a selected edge always sets the flag next cycle
    assert_cap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flag);
    // R10: capture mode keeps the output low
    assert_cap_out_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.cap_mode |-> !ch_out);
endmodule

// File: rtl/irt_timer.sv
// Module: top of the five-channel timer. Holds the control, period and
// flag registers, the 16-bit main counter and the read mux. Instantiates the
// main prescaler, the carrier timer and the channels. In infrared mode the
// counter steps on carrier wraps, and channel 0 is gated by the carrier.
// Assumes single-cycle register writes and a combinational read.
module irt_timer #(
    parameter int NCH   = 5,
    parameter int CNT_W = 16,
    parameter int CAR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [irt_pkg::ADDR_W-1:0] wr_addr,
    input  logic [15:0]               wr_data,
    input  logic [irt_pkg::ADDR_W-1:0] rd_addr,
    output logic [15:0]               rd_data,
    input  logic [NCH-1:0]            cap_in,
    output logic [NCH-1:0]            ch_out,
    output logic                      irq,
    output logic                      carrier_out,
    output logic                      ir_out
);
    import irt_pkg::*;

    localparam int CFG_W = $bits(ch_cfg_t);

    logic [5:0]       ctrl_q;
    logic             run, ir_mode;
    logic [1:0]       main_sel, car_sel;
    logic [CNT_W-1:0] cnt_q, per_sh_q, per_q;
    logic             ovf_q;
    logic             pre_tick, car_wrap, step, wrap;
    logic [2*CAR_W-1:0] car_rd;
    logic [NCH-1:0]   cap_flag;
    logic [CNT_W-1:0] ch_rd [NCH];
    ch_cfg_t          cfg_q [NCH];
    logic             flg_wr;

    assign run      = ctrl_q[0];
    assign main_sel = ctrl_q[2:1];
    assign ir_mode  = ctrl_q[3];
    assign car_sel  = ctrl_q[5:4];
    assign flg_wr   = wr_en && (wr_addr == ADDR_W'(A_FLAGS));

    irt_prescaler #(.CNT_W(7)) i_main_pre (
        .clk(clk), .rst_n(rst_n), .en(run), .sel(main_sel), .tick(pre_tick)
    );

    irt_carrier #(.W(CAR_W)) i_carrier (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(car_sel),
        .wr(wr_en && (wr_addr == ADDR_W'(A_CAR))),
        .wdata(wr_data[2*CAR_W-1:0]),
        .car_out(carrier_out), .car_wrap(car_wrap), .rd_val(car_rd)
    );

    // Counter advance source: carrier periods in infrared mode
    assign step = run && (ir_mode ? car_wrap : pre_tick);
    assign wrap = step && (cnt_q >= per_q);

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(A_CTRL))
            ctrl_q <= wr_data[5:0];
    end

    // Period shadow and active value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh_q <= '0;
            per_q    <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_W'(A_PER))
                per_sh_q <= wr_data;
            if (wrap || !run)
                per_q <= per_sh_q;
        end
    end

    // Main counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wrap)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    // Overflow flag: set on wrap, write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (wrap)
            ovf_q <= 1'b1;
        else if (flg_wr && wr_data[0])
            ovf_q <= 1'b0;
    end

    // Channel array with per-channel configuration registers
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Configuration register of channel i
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(A_CFG + i))
                cfg_q[i] <= wr_data[CFG_W-1:0];
        end

        irt_channel #(.W(CNT_W)) i_ch (
            .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap), .cnt(cnt_q),
            .cfg(cfg_q[i]),
            .cmp_wr(wr_en && wr_addr == ADDR_W'(A_CMP + i)),
            .wdata(wr_data), .flag_clr(flg_wr && wr_data[1+i]),
            .cap_in(cap_in[i]), .ch_out(ch_out[i]), .flag(cap_flag[i]),
            .rd_val(ch_rd[i])
        );
    end

    assign irq    = ovf_q || (|cap_flag);
    assign ir_out = ir_mode && ch_out[0] && carrier_out;

    // Register read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_CTRL):  rd_data = {10'd0, ctrl_q};
            ADDR_W'(A_PER):   rd_data = per_q;
            ADDR_W'(A_CAR):   rd_data = car_rd;
            ADDR_W'(A_FLAGS): rd_data = 16'({cap_flag, ovf_q});
            ADDR_W'(A_COUNT): rd_data = cnt_q;
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(A_CFG + i))
                rd_data = 16'(cfg_q[i]);
            if (rd_addr == ADDR_W'(A_CMP + i))
                rd_data = ch_rd[i];
        end
    end

    // R3: a wrap always returns the counter to zero
    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));
    // R3: a wrap always leaves the overflow flag set
    assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_q);
    // R3: a stopped timer keeps its count
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));
    // R7: modulated output appears only in infrared mode
    assert_ir_mode_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ir_out |-> ir_mode);
endmodule

// File: tb/test_irt_timer.sv
// Bench: directed and seeded-random checks of the five-channel timer.
module test_irt_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;
    logic [4:0]  cap_in, ch_out;
    logic        irq, carrier_out, ir_out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    irt_timer i_irt_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .ch_out(ch_out), .irq(irq),
        .carrier_out(carrier_out), .ir_out(ir_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 5'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count cycles a selected output is high: 0..4 channel, 5 carrier, 6 ir
    task automatic high_count(input int which, input int n, output int hc);
        hc = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (which < 5) hc += int'(ch_out[which]);
            else if (which == 5) hc += int'(carrier_out);
            else hc += int'(ir_out);
        end
    endtask

    function automatic int exp_high(input int c, input int p, input int div);
        return ((c < p + 1) ? c : p + 1) * div;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int v, v2, hc, seed_dummy, p, c, ps, div;
        seed_dummy = $urandom(32'h5eed);
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; cap_in = '0;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 ch_out", int'(ch_out), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 carrier_out", int'(carrier_out), 0);
        chk("R1 ir_out", int'(ir_out), 0);
        rd(4, v); chk("R1 count", v, 0);
        rd(3, v); chk("R1 flags", v, 0);

        // R4/R5 directed duty: P=9, ch0=4, ch1=0, ch2=20
        wr(1, 9); wr(16, 4); wr(17, 0); wr(18, 20);
        wr(0, 1);
        idle(30);
        high_count(0, 10, hc); chk("R4 ch0 duty", hc, 4);
        high_count(1, 10, hc); chk("R5 zero compare", hc, 0);
        high_count(2, 10, hc); chk("R4 compare above period", hc, 10);

        // R3 counter bound: max seen equals period
        v2 = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            rd(4, v);
            if (v > v2) v2 = v;
        end
        chk("R3 count max", v2, 9);
        rd(3, v); chk("R3 overflow flag", v & 1, 1);
        chk("R3 irq", int'(irq), 1);
        wr(0, 0); wr(3, 1); idle(1);
        rd(3, v); chk("R3 flag clear", v & 1, 0);
        chk("R3 irq clear", int'(irq), 0);

        // R2 prescale /8, /32, /128
        wr(0, 1 | (1 << 1)); idle(200);
        high_count(0, 80, hc); chk("R2 div8", hc, 32);
        wr(0, 0); wr(1, 3); wr(16, 2);
        wr(0, 1 | (2 << 1)); idle(300);
        high_count(0, 128, hc); chk("R2 div32", hc, 64);
        wr(0, 1 | (3 << 1)); idle(1100);
        high_count(0, 512, hc); chk("R2 div128", hc, 256);

        // R6 shadowing while running, immediate while stopped
        wr(0, 0); wr(1, 9); wr(16, 4);
        wr(0, 1 | (3 << 1)); idle(50);
        wr(16, 7); idle(2);
        rd(16, v); chk("R6 running compare held", v, 4);
        idle(1300);
        rd(16, v); chk("R6 compare after wrap", v, 7);
        wr(0, 0); wr(16, 5); idle(2);
        rd(16, v); chk("R6 stopped compare immediate", v, 5);

        // R7/R9 infrared mode: P=3, ch0=2, carrier period 4 compare 2
        wr(1, 3); wr(16, 2); wr(2, (2 << 8) | 4);
        wr(0, 1 | (1 << 3)); idle(100);
        high_count(5, 5, hc);  chk("R9 carrier duty", hc, 2);
        high_count(0, 20, hc); chk("R7 ch0 per carrier steps", hc, 10);
        high_count(6, 20, hc); chk("R7 modulated output", hc, 4);
        wr(0, 1); idle(20);
        high_count(6, 20, hc); chk("R7 ir_out off outside mode", hc, 0);

        // R8/R10 capture on channel 3 against frozen counts
        wr(0, 0); wr(1, 1000); wr(19, 500); wr(3, 16'h3e);
        wr(0, 1); idle(37); wr(0, 0);
        rd(4, v);
        wr(11, 3);
        idle(2);
        chk("R10 capture output low", int'(ch_out[3]), 0);
        cap_in[3] = 1'b1; idle(6);
        rd(3, v2); chk("R8 rising flag", (v2 >> 4) & 1, 1);
        rd(19, v2); chk("R8 rising value", v2, v);
        wr(3, 1 << 4);
        cap_in[3] = 1'b0; idle(6);
        rd(3, v2); chk("R8 falling ignored", (v2 >> 4) & 1, 0);
        wr(11, 7);
        wr(0, 1); idle(23); wr(0, 0);
        rd(4, v);
        cap_in[3] = 1'b1; idle(6);
        rd(19, v2); chk("R8 both rising value", v2, v);
        wr(3, 1 << 4);
        wr(0, 1); idle(19); wr(0, 0);
        rd(4, v);
        cap_in[3] = 1'b0; idle(6);
        rd(3, v2); chk("R8 both falling flag", (v2 >> 4) & 1, 1);
        rd(19, v2); chk("R8 both falling value", v2, v);
        wr(3, 1 << 4); wr(11, 1);
        wr(0, 1); idle(11); wr(0, 0);
        cap_in[3] = 1'b1; idle(6); cap_in[3] = 1'b0; idle(6);
        rd(3, v2); chk("R8 no edge selected flag", (v2 >> 4) & 1, 0);
        rd(19, v2); chk("R8 no edge selected value", v2, v);

        // R4 random period/compare pairs at /1 and /8
        for (int it = 0; it < 10; it++) begin
            p  = 2 + int'($urandom_range(28));
            c  = int'($urandom_range(p + 2));
            ps = int'($urandom_range(1));
            div = (ps == 0) ? 1 : 8;
            wr(0, 0); wr(1, p); wr(16, c);
            wr(0, 1 | (ps << 1));
            idle(2 * (p + 1) * div + 2);
            high_count(0, (p + 1) * div, hc);
            chk("R4 random duty", hc, exp_high(c, p, div));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule